// File: doc/BRIEF.md
# Random Number Result Register Bank

This block is the register-side front end of a hardware random number generator. A 32-bit word-addressed bus with address, write data, write enable and a combinational read-data return gives software access to a 128-bit result slot, a status/acknowledge location, a control register, a configuration register, two oscillator registers and a fixed revision word. The entropy source is outside the block. It offers 128-bit values on a valid strobe and is held off by a stall output.

A small slot state machine owns the result. Its states are SLOT_EMPTY, SLOT_LOAD and SLOT_FULL. The transition EMPTY->LOAD happens when a value is offered while the slot is empty, and the value is latched on that edge. LOAD->FULL happens unconditionally on the next edge, and ready becomes visible there. FULL->EMPTY happens when software writes the acknowledge bit. Software polls ready, reads the four result words and then acknowledges, which frees the slot for the next value. Configuration is locked while the generator enable bit is set.

Top module: `rng_regbank`

## Requirements
- R1: After reset, status, control, configuration, oscillator-enable and detune all read 0, `gen_stall` is 0, and the result words read 0.
- R2: A value offered with `gen_valid` while `gen_stall` is 0 is latched. Word 0x00 returns bits [31:0], 0x04 returns [63:32], 0x08 returns [95:64] and 0x0C returns [127:96].
- R3: In the cycle after the latch edge, `gen_stall` is 1 and ready (status 0x10 bit 0) is still 0. One cycle later, ready reads 1.
- R4: While `gen_stall` is 1, offered values are ignored and the four result words keep their values.
- R5: A write to 0x10 with bit 0 set while ready is 1 clears ready and `gen_stall` on the next cycle. A write to 0x10 with bit 0 clear has no effect.
- R6: The control register at 0x14 holds the generator enable at bit 10. All other bits of control read 0.
- R7: The configuration register at 0x18 holds noise blocks in bits [7:0] and sample cycles in bits [23:16], and all other bits read 0. A write to it takes effect only while the enable bit is 0 and is ignored otherwise.
- R8: The oscillator-enable mask at 0x20 is 24 bits wide, and bits [31:24] read 0. The detune register at 0x24 holds all 32 bits.
- R9: The revision word at 0x7C reads major in [27:24], minor in [23:20] and patch in [19:16], with the identifier in [7:0]. All other bits are 0. With the default parameters it reads 0x0213005A, and writes to it are ignored.
- R10: Reads of unmapped or unaligned offsets return 0. Writes to the result words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| gen_valid | input | 1 | Entropy source offers a value |
| gen_data | input | 128 | Offered 128-bit value |
| gen_stall | output | 1 | Slot occupied; offers are not taken |

## Verification
The assertions assume that the entropy source treats `gen_stall` as a refusal and may hold or change its offer while stalled. They also assume that the bus performs at most one write per cycle and that reset is only released synchronously to the clock. The stimulus changes every input half a period away from the rising edge and issues one bus access per task call. It deliberately offers values while stalled, so the properties on the held result and on the locked configuration are exercised against real conflicting traffic rather than idle inputs.

// File: rtl/rng_regbank_pkg.sv
package rng_regbank_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_WORD0  = 7'h00;
    localparam logic [ADDR_W-1:0] OFF_WORD1  = 7'h04;
    localparam logic [ADDR_W-1:0] OFF_WORD2  = 7'h08;
    localparam logic [ADDR_W-1:0] OFF_WORD3  = 7'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 7'h10;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 7'h14;
    localparam logic [ADDR_W-1:0] OFF_CFG    = 7'h18;
    localparam logic [ADDR_W-1:0] OFF_OSCEN  = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_DETUNE = 7'h24;
    localparam logic [ADDR_W-1:0] OFF_REV    = 7'h7C;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_LOAD  = 2'd1,
        SLOT_FULL  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rng_slot_fsm.sv
module rng_slot_fsm
    import rng_regbank_pkg::*;
#(
    parameter int RES_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_valid,
    input  logic [RES_W-1:0] gen_data,
    input  logic             ack,
    output logic [RES_W-1:0] result,
    output logic             ready,
    output logic             stall
);
    slot_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (gen_valid) state_d = SLOT_LOAD;
            SLOT_LOAD:                 state_d = SLOT_FULL;
            SLOT_FULL:  if (ack)       state_d = SLOT_EMPTY;
            default:                   state_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        ready = (state_q == SLOT_FULL);
        stall = (state_q != SLOT_EMPTY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                result <= '0;
        else if (state_q == SLOT_EMPTY && gen_valid) result <= gen_data;
    end

    AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(stall) && !$past(ready)); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid && stall) |=> $stable(result)); // R4
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && ack) |=> !ready && !stall); // R5
endmodule

// File: rtl/rng_cfg_regs.sv
module rng_cfg_regs
    import rng_regbank_pkg::*;
#(
    parameter int OSC_W  = 24,
    parameter int EN_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_cfg,
    input  logic              wr_osc,
    input  logic              wr_det,
    input  logic [DATA_W-1:0] wdata,
    output logic              trng_en,
    output logic [7:0]        noise_blocks,
    output logic [7:0]        sample_cycles,
    output logic [OSC_W-1:0]  osc_en,
    output logic [DATA_W-1:0] osc_detune
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trng_en       <= 1'b0;
            noise_blocks  <= '0;
            sample_cycles <= '0;
            osc_en        <= '0;
            osc_detune    <= '0;
        end else begin
            if (wr_ctrl) trng_en <= wdata[EN_BIT];
            if (wr_cfg && !trng_en) begin
                noise_blocks  <= wdata[7:0];
                sample_cycles <= wdata[23:16];
            end
            if (wr_osc) osc_en     <= wdata[OSC_W-1:0];
            if (wr_det) osc_detune <= wdata;
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        trng_en |=> $stable(noise_blocks) && $stable(sample_cycles)); // R7
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_ctrl, wr_cfg, wr_osc, wr_det}) <= 1); // R6
endmodule

// File: rtl/rng_regbank.sv
module rng_regbank
    import rng_regbank_pkg::*;
#(
    parameter int         RES_W     = 128,
    parameter int         OSC_W     = 24,
    parameter int         EN_BIT    = 10,
    parameter logic [3:0] REV_MAJOR = 4'h2,
    parameter logic [3:0] REV_MINOR = 4'h1,
    parameter logic [3:0] REV_PATCH = 4'h3,
    parameter logic [7:0] REV_ID    = 8'h5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [6:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_we,
    output logic [31:0]        bus_rdata,
    input  logic               gen_valid,
    input  logic [RES_W-1:0]   gen_data,
    output logic               gen_stall
);
    localparam int NWORDS = RES_W / DATA_W;

    logic [RES_W-1:0]  result;
    logic              ready, ack;
    logic              trng_en;
    logic [7:0]        noise_blocks, sample_cycles;
    logic [OSC_W-1:0]  osc_en;
    logic [DATA_W-1:0] osc_detune;
    logic [DATA_W-1:0] word_rd [NWORDS];

    assign ack = bus_we && bus_addr == OFF_STATUS && bus_wdata[0];

    rng_slot_fsm #(.RES_W(RES_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .gen_valid(gen_valid), .gen_data(gen_data),
        .ack(ack), .result(result), .ready(ready), .stall(gen_stall)
    );

    rng_cfg_regs #(.OSC_W(OSC_W), .EN_BIT(EN_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(bus_we && bus_addr == OFF_CTRL),
        .wr_cfg (bus_we && bus_addr == OFF_CFG),
        .wr_osc (bus_we && bus_addr == OFF_OSCEN),
        .wr_det (bus_we && bus_addr == OFF_DETUNE),
        .wdata(bus_wdata), .trng_en(trng_en), .noise_blocks(noise_blocks),
        .sample_cycles(sample_cycles), .osc_en(osc_en), .osc_detune(osc_detune)
    );

    for (genvar w = 0; w < NWORDS; w++) begin : g_words
        assign word_rd[w] = result[w*DATA_W +: DATA_W];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_WORD0:  bus_rdata = word_rd[0];
            OFF_WORD1:  bus_rdata = word_rd[1];
            OFF_WORD2:  bus_rdata = word_rd[2];
            OFF_WORD3:  bus_rdata = word_rd[3];
            OFF_STATUS: bus_rdata = {31'd0, ready};
            OFF_CTRL:   bus_rdata[EN_BIT] = trng_en;
            OFF_CFG:    bus_rdata = {8'd0, sample_cycles, 8'd0, noise_blocks};
            OFF_OSCEN:  bus_rdata[OSC_W-1:0] = osc_en;
            OFF_DETUNE: bus_rdata = osc_detune;
            OFF_REV:    bus_rdata = {4'd0, REV_MAJOR, REV_MINOR, REV_PATCH, 8'd0, REV_ID};
            default:    bus_rdata = '0;
        endcase
    end

    AST_WORDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(result)); // R2
    AST_STALL_COVERS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> gen_stall); // R4
endmodule

// File: tb/rng_regbank_test.sv
module rng_regbank_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_rdata;
    logic         gen_valid = 1'b0;
    logic [127:0] gen_data = '0;
    logic         gen_stall;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [127:0] expq[$];

    always #2 clk = ~clk;

    rng_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .gen_valid(gen_valid),
        .gen_data(gen_data), .gen_stall(gen_stall)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // driver: offers a value; pushes it as expected only if the slot is free
    task automatic offer(logic [127:0] v);
        @(negedge clk);
        if (!gen_stall) expq.push_back(v);
        gen_valid = 1'b1; gen_data = v;
        @(negedge clk);
        gen_valid = 1'b0;
    endtask

    // monitor: waits for ready, pops expected item and compares the words
    task automatic consume(string tag);
        logic [31:0] d;
        logic [127:0] e;
        for (int i = 0; i < 20; i++) begin
            bus_read(7'h10, d);
            if (d[0]) break;
        end
        check({tag, " R3 ready"}, d, 32'h1);
        e = (expq.size() > 0) ? expq.pop_front() : '0;
        for (int w = 0; w < 4; w++) begin
            bus_read(7'(4*w), d);
            check({tag, " R2 word"}, d, e[32*w +: 32]);
        end
        bus_write(7'h10, 32'h1);
        bus_read(7'h10, d);
        check({tag, " R5 ack clears"}, d, 32'h0);
        check({tag, " R5 stall released"}, {31'd0, gen_stall}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(7'h10, d); check("R1 status", d, 0);
        bus_read(7'h14, d); check("R1 ctrl", d, 0);
        bus_read(7'h18, d); check("R1 cfg", d, 0);
        bus_read(7'h20, d); check("R1 oscen", d, 0);
        bus_read(7'h24, d); check("R1 detune", d, 0);
        bus_read(7'h0C, d); check("R1 word3", d, 0);
        check("R1 stall", {31'd0, gen_stall}, 0);

        // R3 timing: one edge after offer stall=1 ready=0, next edge ready=1
        @(negedge clk);
        expq.push_back(128'h0123456789ABCDEF_FEDCBA9876543210);
        gen_valid = 1'b1; gen_data = 128'h0123456789ABCDEF_FEDCBA9876543210;
        @(negedge clk);
        gen_valid = 1'b0;
        check("R3 stall after latch", {31'd0, gen_stall}, 1);
        bus_addr = 7'h10; #1 check("R3 ready not yet", bus_rdata, 0);
        @(negedge clk);
        #1 check("R3 ready next cycle", bus_rdata, 1);

        // R4 offers while stalled ignored
        offer(128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
        bus_read(7'h00, d); check("R4 word0 held", d, 32'h76543210);
        // R5 write without bit0 has no effect
        bus_write(7'h10, 32'hFFFF_FFFE);
        bus_read(7'h10, d); check("R5 no-ack write", d, 1);
        // R10 writes to result words ignored
        bus_write(7'h04, 32'h1234_5678);
        bus_read(7'h04, d); check("R10 word write ignored", d, 32'hFEDCBA98);
        consume("first");

        // more patterns through the scoreboard
        offer({4{32'hA5A5_5A5A}});
        consume("pattern A");
        offer(128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0001);
        consume("pattern B");

        // R7 config writes when disabled
        bus_write(7'h18, 32'hFFFF_FFFF);
        bus_read(7'h18, d); check("R7 cfg writable", d, 32'h00FF_00FF);
        bus_write(7'h18, 32'h0022_0005);
        // R6 control enable
        bus_write(7'h14, 32'hFFFF_FFFF);
        bus_read(7'h14, d); check("R6 ctrl bit10", d, 32'h0000_0400);
        bus_write(7'h18, 32'h0011_0009);
        bus_read(7'h18, d); check("R7 cfg locked", d, 32'h0022_0005);
        bus_write(7'h14, 32'h0);
        bus_read(7'h14, d); check("R6 ctrl cleared", d, 0);
        bus_write(7'h18, 32'h0011_0009);
        bus_read(7'h18, d); check("R7 cfg unlocked", d, 32'h0011_0009);

        // R8 oscillator registers
        bus_write(7'h20, 32'hFFFF_FFFF);
        bus_read(7'h20, d); check("R8 oscen width", d, 32'h00FF_FFFF);
        bus_write(7'h24, 32'hC3C3_3C3C);
        bus_read(7'h24, d); check("R8 detune", d, 32'hC3C3_3C3C);

        // R9 revision
        bus_read(7'h7C, d); check("R9 revision", d, 32'h0213_005A);
        bus_write(7'h7C, 32'hFFFF_FFFF);
        bus_read(7'h7C, d); check("R9 revision write ignored", d, 32'h0213_005A);

        // R10 unmapped / unaligned
        bus_read(7'h1C, d); check("R10 unmapped 0x1C", d, 0);
        bus_read(7'h40, d); check("R10 unmapped 0x40", d, 0);
        bus_read(7'h15, d); check("R10 unaligned", d, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule